// File: doc/BRIEF.md
# Subsystem Control and Clock-Source Register Block

This block is a small memory-mapped register window on a 32-bit processor bus. Software uses it to control a downstream processor network and a video controller on the same module. It holds four single-bit control registers: a reset line and an analyse line for the downstream network, a reset line for the video controller, and the selector for the pixel-clock source. It also reports the state of the downstream network's error line.

The four control registers are write-only. The error status is the only readable value, and it sits at the same offset as the downstream reset register. A write to offset 0x00 therefore sets the reset line, and a read from offset 0x00 returns the error status. The error input comes from an open-collector wired net and is active low. It is brought into the clock domain through a multi-stage synchronizer before it can be read. Read data is combinational and is valid in the same cycle as the read strobe. A write takes effect at the clock edge that samples it.

Top module: `ctl_regs`

## Requirements
- R1: After reset, `sub_rst`, `sub_ana`, `vid_rst` and `clk_src` are all 0, and a read of offset 0x00 returns 0 while `sub_err_n` is high.
- R2: A write to byte offset 0x00 loads bit 0 of the write data into `sub_rst` (1 = asserted) at the sampling clock edge. Bits 31:1 of the write data are ignored.
- R3: A write to byte offset 0x04 loads bit 0 of the write data into `sub_ana` (1 = asserted) at the sampling clock edge.
- R4: A write to byte offset 0xF0 loads bit 0 of the write data into `vid_rst` (1 = video controller held in reset, 0 = enabled) at the sampling clock edge.
- R5: A write to byte offset 0xF4 loads bit 0 of the write data into `clk_src` (0 = module clock, 1 = crystal) at the sampling clock edge.
- R6: A read of byte offset 0x00 returns the synchronized error status in bit 0 (1 when `sub_err_n` is low) and 0 in bits 31:1. Reading has no effect on `sub_rst`.
- R7: A change on `sub_err_n` reaches the readable status after exactly SYNC_STAGES rising clock edges (2 by default).
- R8: `bus_rdata` is 0 for reads of offsets 0x04, 0xF0 and 0xF4, for reads of any other offset, and whenever `bus_rd` is low.
- R9: A write to any offset other than the four mapped offsets, including offsets that are not word-aligned, changes no output.
- R10: A write to one mapped offset changes only that offset's output. The other three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| sub_err_n | input | 1 | Active-low error line from the downstream network |
| sub_rst | output | 1 | Downstream network reset, active high |
| sub_ana | output | 1 | Downstream network analyse, active high |
| vid_rst | output | 1 | Video controller reset, active high |
| clk_src | output | 1 | Pixel-clock source select |

## Verification
The first sign of a wrong write decode is a control output that moves, or fails to move, at the edge right after a write strobe, and none of these outputs is visible through a read. The bench therefore checks all four outputs after every write, including writes whose target is a different register. A synchronizer that is too short or too long shows up as the error status at offset 0x00 changing one edge early or late. The bench steps the error input and samples the status after each of the edges that follow. A read decode that does not take the bus direction into account shows up as data on the bus at the write-only offsets, or as data while the read strobe is low.

// File: rtl/ctl_regs_pkg.sv
package ctl_regs_pkg;

  localparam int unsigned NUM_CTRL = 4;

  typedef enum logic [1:0] {
    CTRL_SUB_RST = 2'd0,
    CTRL_SUB_ANA = 2'd1,
    CTRL_VID_RST = 2'd2,
    CTRL_CLK_SRC = 2'd3
  } ctrl_idx_e;

  localparam logic [7:0] OFS_SUB_RST = 8'h00;
  localparam logic [7:0] OFS_SUB_ANA = 8'h04;
  localparam logic [7:0] OFS_VID_RST = 8'hF0;
  localparam logic [7:0] OFS_CLK_SRC = 8'hF4;
  localparam logic [7:0] OFS_ERR_STS = 8'h00;

  function automatic logic [7:0] ctrl_offset(input int unsigned idx);
    logic [7:0] ofs;
    case (idx)
      0:       ofs = OFS_SUB_RST;
      1:       ofs = OFS_SUB_ANA;
      2:       ofs = OFS_VID_RST;
      default: ofs = OFS_CLK_SRC;
    endcase
    return ofs;
  endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = d_async;
      end else begin : g_rest
        always_comb stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  output logic [NUM_CTRL-1:0] wr_hit,
  output logic                rd_sts_hit
);

  generate
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_hit
      always_comb wr_hit[i] = wr && (addr == ADDR_W'(ctrl_offset(i)));
    end
  endgenerate

  always_comb rd_sts_hit = rd && (addr == ADDR_W'(OFS_ERR_STS));

  // R10: at most one control register is addressed by a single write
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  // R9: a write that hits no register came from an unmapped offset
  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (wr_hit == '0)) |-> (addr != ADDR_W'(OFS_SUB_RST)) && (addr != ADDR_W'(OFS_CLK_SRC)));

endmodule

// File: rtl/ctl_ctrl_bit.sv
module ctl_ctrl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic load_val,
  output logic q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) begin
      q_nxt = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import ctl_regs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sub_err_n,
  output logic              sub_rst,
  output logic              sub_ana,
  output logic              vid_rst,
  output logic              clk_src
);

  logic [NUM_CTRL-1:0] wr_hit;
  logic                rd_sts_hit;
  logic [NUM_CTRL-1:0] ctrl_q;
  logic                err_n_sync;
  logic                err_sts;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:1];

  ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .wr_hit     (wr_hit),
    .rd_sts_hit (rd_sts_hit)
  );

  generate
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
      ctl_ctrl_bit u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (wr_hit[i]),
        .load_val (bus_wdata[0]),
        .q        (ctrl_q[i])
      );
    end
  endgenerate

  ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_err_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sub_err_n),
    .q_sync  (err_n_sync)
  );

  assign err_sts = ~err_n_sync;

  always_comb begin
    bus_rdata = '0;
    if (rd_sts_hit) begin
      bus_rdata[0] = err_sts;
    end
  end

  assign sub_rst = ctrl_q[CTRL_SUB_RST];
  assign sub_ana = ctrl_q[CTRL_SUB_ANA];
  assign vid_rst = ctrl_q[CTRL_VID_RST];
  assign clk_src = ctrl_q[CTRL_CLK_SRC];

  // R2: a write to offset 0x00 lands bit 0 in the downstream reset
  assert_sub_rst_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_SUB_RST)) |=> (sub_rst == $past(bus_wdata[0])));

  // R5: without a write to 0xF4 the clock select holds
  assert_clk_src_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(OFS_CLK_SRC)) |=> $stable(clk_src));

  // R6: a read of offset 0x00 never drives the upper bits
  assert_sts_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_ERR_STS)) |-> (bus_rdata[DATA_W-1:1] == '0));

  // R8: no data on the bus while the read strobe is low
  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

  // R8: the write-only offsets read back as zero
  assert_wo_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADDR_W'(OFS_SUB_ANA) || bus_addr == ADDR_W'(OFS_VID_RST)
                || bus_addr == ADDR_W'(OFS_CLK_SRC))) |-> (bus_rdata == '0));

endmodule

// File: tb/ctl_regs_tb.sv
module ctl_regs_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        sub_err_n;
  logic        sub_rst, sub_ana, vid_rst, clk_src;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sub_err_n(sub_err_n), .sub_rst(sub_rst), .sub_ana(sub_ana),
    .vid_rst(vid_rst), .clk_src(clk_src)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic [3:0] exp);
    check(req, {28'd0, clk_src, vid_rst, sub_ana, sub_rst}, {28'd0, exp});
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check_outs("R1", 4'b0000);
    bus_read(8'h00, d);
    check("R1", d, 32'd0);
  endtask

  task automatic t_each_reg;
    bus_write(8'h00, 32'hFFFF_FFFF);
    check_outs("R2", 4'b0001);
    bus_write(8'h04, 32'h0000_0001);
    check_outs("R3", 4'b0011);
    bus_write(8'hF0, 32'h0000_0001);
    check_outs("R4", 4'b0111);
    bus_write(8'hF4, 32'h0000_0001);
    check_outs("R5", 4'b1111);
    bus_write(8'h00, 32'hFFFF_FFFE);
    check_outs("R2", 4'b1110);
    bus_write(8'hF0, 32'h0000_0000);
    check_outs("R10", 4'b1010);
    bus_write(8'h04, 32'h8000_0000);
    check_outs("R3", 4'b1000);
    bus_write(8'hF4, 32'h0000_0002);
    check_outs("R5", 4'b0000);
  endtask

  task automatic t_unmapped;
    bus_write(8'h00, 32'h1);
    bus_write(8'hF4, 32'h1);
    bus_write(8'h08, 32'h1);
    check_outs("R9", 4'b1001);
    bus_write(8'h01, 32'h0);
    check_outs("R9", 4'b1001);
    bus_write(8'hF5, 32'h0);
    check_outs("R9", 4'b1001);
    bus_write(8'hF8, 32'hFFFF_FFFF);
    check_outs("R9", 4'b1001);
  endtask

  task automatic t_reads;
    logic [31:0] d;
    bus_write(8'h04, 32'h1);
    bus_write(8'hF0, 32'h1);
    bus_read(8'h04, d); check("R8", d, 32'd0);
    bus_read(8'hF0, d); check("R8", d, 32'd0);
    bus_read(8'hF4, d); check("R8", d, 32'd0);
    bus_read(8'h10, d); check("R8", d, 32'd0);
    bus_read(8'h00, d); check("R6", d, 32'd0);
    check_outs("R6", 4'b1111);
  endtask

  task automatic t_error;
    logic [31:0] d;
    @(negedge clk);
    sub_err_n = 1'b0;
    bus_addr = 8'h00; bus_rd = 1'b1;
    #1 check("R7", bus_rdata, 32'd0);
    @(negedge clk);
    check("R7", bus_rdata, 32'd0);
    @(negedge clk);
    check("R7", bus_rdata, 32'd1);
    bus_rd = 1'b0;
    #1 check("R8", bus_rdata, 32'd0);
    bus_read(8'h00, d); check("R6", d, 32'd1);
    bus_read(8'h04, d); check("R8", d, 32'd0);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, d); check("R6", d, 32'd1);
    check("R6", {31'd0, sub_rst}, 32'd0);
    @(negedge clk);
    sub_err_n = 1'b1;
    bus_addr = 8'h00; bus_rd = 1'b1;
    @(negedge clk);
    check("R7", bus_rdata, 32'd1);
    @(negedge clk);
    check("R7", bus_rdata, 32'd0);
    bus_rd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    bus_rd = 1'b0; sub_err_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_each_reg();
    t_unmapped();
    t_reads();
    t_error();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule